// File: doc/BRIEF.md
# Legacy NMI Source and Mask Gate

This block collects two non-maskable interrupt causes, a system error and an I/O channel check, and drives one edge-sensitive NMI line to the processor. Software reaches it over a small 8-bit I/O bus with an address, read and write strobes and write data. Three byte ports are decoded. The status/control port reports which causes are pending, and its low nibble disables and clears each cause. The index port is shared with a companion register file: bit 7 of a write is the NMI mask and bits 6:0 pick an entry. The data port reads and writes the entry that the index selects.

A pending cause only reaches the processor while the mask is clear. The processor's input reacts to edges, so a cause that is still pending after a service routine would otherwise be lost. Software re-arms the line by writing the index port once with the mask set and once with it clear. The line drops and then rises again, and the processor sees a new edge. The data port read that usually follows each index write returns a defined register-file value and changes no NMI state.

Top module: `legacy_nmi_gate`

## Requirements
- R1: After reset the mask is set, both causes are disabled and no cause is pending. The status port reads 0x0C, the index port reads 0x80, every register-file entry reads 0x00, and `nmi_o` is 0.
- R2: A status port read returns bit 7 = system error pending, bit 6 = channel check pending, bits 5:4 = 0, and bits 3:0 = the last control nibble written. Write bits 7:4 are ignored.
- R3: While its disable bit is 0, a cause's pending bit sets on any cycle its input is 1. It then stays set after the input returns to 0.
- R4: Writing the status port with bit 2 = 1 clears the system error pending bit and keeps it clear, and the input is ignored. Bit 3 does the same for the channel check. Writing the bit back to 0 re-enables the cause.
- R5: Status port bits 1:0 are plain storage that reads back what was written.
- R6: A write to the index port stores bit 7 as the mask (1 = masked) and bits 6:0 as the index. A read of the index port returns both.
- R7: `nmi_o` is 1 exactly when the mask is 0 and at least one enabled cause is pending. While the mask is 1, `nmi_o` is 0.
- R8: With a cause pending, writing the mask to 1 and then to 0 drives `nmi_o` low and then high again, one cycle after each write.
- R9: A data port write stores a byte in the entry selected by the index. A data port read returns that entry's value.
- R10: A data port read changes neither the mask, the pending bits nor `nmi_o`.
- R11: Reads of any other address return 0x00, and writes to any other address change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| io_wr | input | 1 | Write strobe; takes effect at the clock edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 when no read is decoded |
| sys_err_i | input | 1 | System error cause, active high |
| chan_chk_i | input | 1 | I/O channel check cause, active high |
| nmi_o | output | 1 | NMI line to the processor, active high |

## Verification
Several properties are checked on every cycle. A masked line never asserts, and a disabled cause never shows as pending. A pending bit persists until its clear bit is written. Cycles without a write leave the mask and control untouched, and an undecoded read returns zero. Only the bench scenarios can show the rest. These are the full re-arm sequence with its low-then-high transition, the data returned by the register file for different indices, and the exact byte layout of the status port.

// File: rtl/nmi_gate_pkg.sv
// Package: shared constants and types for the legacy NMI gate.
// Assumes an 8-bit I/O bus and a 7-bit register index field.
package nmi_gate_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 7;

    // Control nibble of the status/control port; bit order is decoded by software.
    typedef struct packed {
        logic       chan_dis;   // bit 3
        logic       sys_dis;    // bit 2
        logic [1:0] spare;      // bits 1:0
    } nmi_ctl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_IDX  = 2'd2,
        SEL_DAT  = 2'd3
    } port_sel_e;
endpackage

// File: rtl/nmi_src_latch.sv
// Module: sticky pending bit for one NMI cause.
// Assumes dis_nxt_i is the disable value that holds after this cycle's write.
module nmi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic dis_nxt_i,
    output logic pend_o
);
    // Set on the cause, hold until disabled, and stay clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (dis_nxt_i)
            pend_o <= 1'b0;
        else
            pend_o <= pend_o | src_i;
    end
endmodule

// File: rtl/nmi_regfile.sv
// Module: small byte register file behind the data port.
// Assumes DEPTH <= 2**IW; an out-of-range index reads 0 and ignores writes.
module nmi_regfile #(
    parameter int DEPTH = 128,
    parameter int IW    = 7,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem_q [DEPTH];

    // Clear every entry on reset and store on a data port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i && (int'(idx_i) < DEPTH)) begin
            mem_q[idx_i] <= wdata_i;
        end
    end

    // Return the selected entry without any side effect.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++)
            if (int'(idx_i) == i) rdata_o = mem_q[i];
    end
endmodule

// File: rtl/legacy_nmi_gate.sv
// Module: gathers two NMI causes, exposes status/control on one port, masks the
// NMI line through the bit 7 of the shared index port, and hosts the register file.
// Assumes single-cycle strobes; read data is combinational within the read cycle.
module legacy_nmi_gate #(
    parameter logic [7:0] STAT_ADDR = 8'h61,
    parameter logic [7:0] IDX_ADDR  = 8'h70,
    parameter logic [7:0] DAT_ADDR  = 8'h71,
    parameter int         RF_DEPTH  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] io_addr,
    input  logic       io_rd,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       sys_err_i,
    input  logic       chan_chk_i,
    output logic       nmi_o
);
    import nmi_gate_pkg::*;

    localparam int NSRC = 2;   // index 1 = system error, index 0 = channel check

    port_sel_e              sel;
    nmi_ctl_t               ctl_q, ctl_nxt;
    logic                   mask_q;
    logic [IDX_W-1:0]       idx_q;
    logic [NSRC-1:0]        src_in, dis_nxt, dis_now, pend;
    logic [DATA_W-1:0]      rf_rdata;

    // Decode the addressed port.
    always_comb begin
        if (io_addr == STAT_ADDR)     sel = SEL_STAT;
        else if (io_addr == IDX_ADDR) sel = SEL_IDX;
        else if (io_addr == DAT_ADDR) sel = SEL_DAT;
        else                          sel = SEL_NONE;
    end

    // Next control nibble: the write value on a status port write, else hold.
    always_comb begin
        ctl_nxt = ctl_q;
        if (io_wr && sel == SEL_STAT) ctl_nxt = nmi_ctl_t'(io_wdata[3:0]);
    end

    // Control register: both causes disabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{chan_dis: 1'b1, sys_dis: 1'b1, spare: 2'b00};
        else        ctl_q <= ctl_nxt;
    end

    // Mask and index register: masked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            idx_q  <= '0;
        end else if (io_wr && sel == SEL_IDX) begin
            mask_q <= io_wdata[7];
            idx_q  <= io_wdata[IDX_W-1:0];
        end
    end

    assign src_in  = {sys_err_i, chan_chk_i};
    assign dis_nxt = {ctl_nxt.sys_dis, ctl_nxt.chan_dis};
    assign dis_now = {ctl_q.sys_dis, ctl_q.chan_dis};

    // One sticky pending bit per cause.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        nmi_src_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_in[g]),
            .dis_nxt_i (dis_nxt[g]),
            .pend_o    (pend[g])
        );
    end

    nmi_regfile #(
        .DEPTH (RF_DEPTH),
        .IW    (IDX_W),
        .DW    (DATA_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (io_wr && sel == SEL_DAT),
        .idx_i   (idx_q),
        .wdata_i (io_wdata),
        .rdata_o (rf_rdata)
    );

    // Read mux: zero unless a decoded read is in progress.
    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (sel)
                SEL_STAT: io_rdata = {pend[1], pend[0], 2'b00, ctl_q};
                SEL_IDX:  io_rdata = {mask_q, idx_q};
                SEL_DAT:  io_rdata = rf_rdata;
                default:  io_rdata = '0;
            endcase
        end
    end

    // NMI line: unmasked OR of enabled pending causes.
    assign nmi_o = !mask_q && (|(pend & ~dis_now));
endmodule

// File: rtl/nmi_gate_chk.sv
// Module: cycle properties of the legacy NMI gate, bound to its top.
// Assumes the bound signal names of legacy_nmi_gate.
module nmi_gate_chk #(
    parameter logic [7:0] STAT_ADDR = 8'h61,
    parameter logic [7:0] IDX_ADDR  = 8'h70,
    parameter logic [7:0] DAT_ADDR  = 8'h71
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] io_addr,
    input logic       io_rd,
    input logic       io_wr,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       nmi_o,
    input logic       mask_q,
    input logic [1:0] pend,
    input logic [1:0] dis_now,
    input logic [3:0] ctl_q
);
    logic stat_wr;
    assign stat_wr = io_wr && io_addr == STAT_ADDR;

    p_masked_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !nmi_o);

    p_dis_clear_sys_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dis_now[1] |-> !pend[1]);

    p_dis_clear_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dis_now[0] |-> !pend[0]);

    p_pend_hold_sys_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[1] && !(stat_wr && io_wdata[2])) |=> pend[1]);

    p_pend_hold_chan_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[0] && !(stat_wr && io_wdata[3])) |=> pend[0]);

    p_read_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> ($stable(mask_q) && $stable(ctl_q)));

    p_rise_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_o) |-> !mask_q);

    p_other_addr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr != STAT_ADDR && io_addr != IDX_ADDR && io_addr != DAT_ADDR)
            |-> io_rdata == 8'h00);
endmodule

bind legacy_nmi_gate nmi_gate_chk #(
    .STAT_ADDR (STAT_ADDR),
    .IDX_ADDR  (IDX_ADDR),
    .DAT_ADDR  (DAT_ADDR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .nmi_o    (nmi_o),
    .mask_q   (mask_q),
    .pend     (pend),
    .dis_now  (dis_now),
    .ctl_q    (ctl_q)
);

// File: tb/legacy_nmi_gate_tb.sv
// Bench: scoreboard for the legacy NMI gate. Read tasks queue expected bytes,
// a monitor pops and compares them while the read strobe is high.
module legacy_nmi_gate_tb;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = '0;
    logic       io_rd = 1'b0;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       sys_err_i = 1'b0;
    logic       chan_chk_i = 1'b0;
    logic       nmi_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    legacy_nmi_gate u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_rd      (io_rd),
        .io_wr      (io_wr),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .sys_err_i  (sys_err_i),
        .chan_chk_i (chan_chk_i),
        .nmi_o      (nmi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pop an expected byte for each read cycle and compare.
    always @(negedge clk) begin
        #2;
        if (io_rd) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: read with no expected item, got %02h", "scoreboard", io_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (io_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: rdata %02h expected %02h", t, io_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pulse(input bit s, input bit c);
        @(negedge clk);
        sys_err_i = s; chan_chk_i = c;
        @(negedge clk);
        sys_err_i = 1'b0; chan_chk_i = 1'b0;
    endtask

    task automatic chk_nmi(input logic e, input string t);
        #2;
        checks++;
        if (nmi_o !== e) begin
            errors++;
            $display("FAIL %s: nmi_o %0b expected %0b", t, nmi_o, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run not finished, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_nmi(1'b0, "R1 nmi after reset");
        rd(8'h61, 8'h0C, "R1 status after reset");
        rd(8'h70, 8'h80, "R1 index after reset");
        rd(8'h71, 8'h00, "R1 entry 0 after reset");
        pulse(1'b1, 1'b1);
        rd(8'h61, 8'h0C, "R4 input ignored while disabled");

        // R3 latch with both causes enabled, R7 masked
        wr(8'h61, 8'h00);
        pulse(1'b1, 1'b0);
        rd(8'h61, 8'h80, "R3 system error latched");
        chk_nmi(1'b0, "R7 held low while masked");
        wr(8'h70, 8'h05);
        chk_nmi(1'b1, "R7 unmasked with pending cause");
        rd(8'h70, 8'h05, "R6 index readback");

        // R8 re-arm: mask then unmask
        wr(8'h70, 8'h85);
        chk_nmi(1'b0, "R8 line low while re-armed");
        wr(8'h70, 8'h05);
        chk_nmi(1'b1, "R8 line high again");

        // R10 data port read has no effect
        rd(8'h71, 8'h00, "R10 dummy read value");
        chk_nmi(1'b1, "R10 nmi unchanged by dummy read");
        rd(8'h61, 8'h80, "R10 status unchanged by dummy read");
        rd(8'h70, 8'h05, "R10 mask unchanged by dummy read");

        // R4 clear of system error, R2 high write bits ignored
        wr(8'h61, 8'hF4);
        rd(8'h61, 8'h04, "R4 system error cleared");
        chk_nmi(1'b0, "R4 nmi drops after clear");

        // R5 spare bits, channel check path
        wr(8'h61, 8'h07);
        rd(8'h61, 8'h07, "R5 spare bits stored");
        pulse(1'b0, 1'b1);
        rd(8'h61, 8'h47, "R2 channel check on bit 6");
        chk_nmi(1'b1, "R7 channel check drives nmi");
        wr(8'h61, 8'h0B);
        rd(8'h61, 8'h0B, "R4 channel check cleared");
        chk_nmi(1'b0, "R4 nmi low after channel clear");

        // R9 register file
        wr(8'h70, 8'h7F);
        wr(8'h71, 8'hA5);
        rd(8'h71, 8'hA5, "R9 entry 127 readback");
        wr(8'h70, 8'h03);
        rd(8'h71, 8'h00, "R9 entry 3 untouched");
        wr(8'h71, 8'h3C);
        wr(8'h70, 8'h7F);
        rd(8'h71, 8'hA5, "R9 entry 127 retained");
        wr(8'h70, 8'h03);
        rd(8'h71, 8'h3C, "R9 entry 3 readback");

        // R11 other addresses
        rd(8'h60, 8'h00, "R11 undecoded read");
        wr(8'h62, 8'hFF);
        wr(8'h72, 8'h80);
        rd(8'h61, 8'h0B, "R11 status unchanged by stray write");
        rd(8'h70, 8'h03, "R11 index unchanged by stray write");

        // R2 both causes together, R7 unmasked
        wr(8'h61, 8'h00);
        pulse(1'b1, 1'b1);
        rd(8'h61, 8'hC0, "R2 both causes pending");
        chk_nmi(1'b1, "R7 both causes drive nmi");
        wr(8'h61, 8'h04);
        chk_nmi(1'b1, "R7 channel check alone keeps nmi");
        rd(8'h61, 8'h44, "R4 only system error cleared");

        @(negedge clk);
        @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule